// File: doc/BRIEF.md
# Masked Interrupt Aggregator

This block collects 64 level-sensitive request lines from peripherals and drives a single interrupt line toward the processor. Software controls each source's mask through two kinds of write-only strobe registers. Writing ones to a set-enable register unmasks the chosen sources. Writing ones to a clear-enable register masks them. Software never writes the mask as a whole, so two handlers can change different sources without a read-modify-write race.

Two pending words report which sources are both requesting and unmasked. The low word covers sources 0-31 and the high word covers sources 32-63. The processor line is a registered OR of every unmasked, requesting source. In a typical system the timer compare lines connect to sources 0-3, the GPIO bank lines connect from source 49 upward, and source 57 carries the combined UART request. None of these connections changes the logic of the block.

The register port is a plain 32-bit interface with a 12-bit byte address. Write data is captured on the clock edge while the write strobe is high. Read data is combinational from the address.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset all enables are 0, `irq_out` is 0, and every pending, set-enable and clear-enable read returns 0.
- R2: A write to 0x210 (sources 0-31) or 0x214 (sources 32-63) enables every source whose data bit is 1. Enables for bits written 0 are unchanged. The change is visible on reads from the clock edge of the write.
- R3: A write to 0x220 (sources 0-31) or 0x224 (sources 32-63) disables every source whose data bit is 1. Enables for bits written 0 are unchanged.
- R4: Reading 0x200 returns src_req[31:0] AND enable[31:0]. Reading 0x204 returns src_req[63:32] AND enable[63:32]. Bit n of each word is source n, or source 32+n for the high word.
- R5: Reading 0x210 or 0x220 returns enable[31:0]. Reading 0x214 or 0x224 returns enable[63:32].
- R6: `irq_out` equals, one clock after any cycle, the OR of src_req AND enable in that cycle.
- R7: A write to a pending address (0x200, 0x204) or to any other unmapped address leaves every enable unchanged. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 64 | Level request from each source |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | 1 | Registered interrupt to the processor |

## Verification
Enable writes take effect at the edge that samples the strobe. Pending and mask reads therefore match the model one time step after the address is placed, at the falling edge that follows the write. `irq_out` lags its inputs by one register: a request or enable change made before edge k appears after edge k, or after edge k+1 when the enable itself changes at edge k. The bench reference model updates at the same edges and is compared against `irq_out` at every falling edge. Register reads are sampled only while the write strobe is low.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] PEND_BASE = 12'h200;
  localparam logic [ADDR_W-1:0] SET_BASE  = 12'h210;
  localparam logic [ADDR_W-1:0] CLR_BASE  = 12'h220;

  // byte address of word idx inside a register group
  function automatic logic [ADDR_W-1:0] reg_off(logic [ADDR_W-1:0] base, int idx);
    return base + ADDR_W'(idx * 4);
  endfunction

  // next mask after a strobe write: set wins only where clear is absent
  function automatic logic [REG_W-1:0] next_mask(logic [REG_W-1:0] cur,
                                                 logic set_s, logic clr_s,
                                                 logic [REG_W-1:0] data);
    logic [REG_W-1:0] s, c;
    s = set_s ? data : '0;
    c = clr_s ? data : '0;
    return (cur | s) & ~c;
  endfunction
endpackage

// File: rtl/irq_enable_word.sv
module irq_enable_word
  import irqc_pkg::*;
#(
  parameter int WIDTH = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (set_stb || clr_stb) en_q <= next_mask(en_q, set_stb, clr_stb, wdata);
  end

  // R2: every bit written 1 to the set strobe is enabled afterwards
  a_r2_set_bits_on: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R3: every bit written 1 to the clear strobe is disabled afterwards
  a_r3_clr_bits_off: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(wdata)) == '0));

  // R2 and R3: zero bits of a strobe write keep their enable
  a_r2_r3_zero_bits_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb || clr_stb) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irqc_pkg::*;
#(
  parameter int NUM_WORDS = 2
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [NUM_WORDS*REG_W-1:0] en_all,
  input  logic [NUM_WORDS*REG_W-1:0] pend_all,
  output logic [REG_W-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == reg_off(PEND_BASE, w))
        rdata = pend_all[w*REG_W +: REG_W];
      if (addr == reg_off(SET_BASE, w) || addr == reg_off(CLR_BASE, w))
        rdata = en_all[w*REG_W +: REG_W];
    end
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pend,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend;
  end

  // R6: any enabled pending source raises the line one cycle later
  a_r6_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> irq_q);

  // R6: no enabled pending source drops the line one cycle later
  a_r6_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend) |=> !irq_q);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq_out
);
  localparam int NUM_WORDS = NUM_SRC / REG_W;

  logic [NUM_WORDS-1:0]       set_hit;
  logic [NUM_WORDS-1:0]       clr_hit;
  logic [NUM_SRC-1:0]         en_all;
  logic [NUM_SRC-1:0]         pend_vec;
  logic                       mask_write;

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign set_hit[w] = reg_wr && (reg_addr == reg_off(SET_BASE, w));
      assign clr_hit[w] = reg_wr && (reg_addr == reg_off(CLR_BASE, w));

      irq_enable_word #(.WIDTH(REG_W)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_hit[w]),
        .clr_stb (clr_hit[w]),
        .wdata   (reg_wdata),
        .en_q    (en_all[w*REG_W +: REG_W])
      );
    end
  endgenerate

  assign mask_write = (|set_hit) || (|clr_hit);
  assign pend_vec   = src_req & en_all;

  irq_readback #(.NUM_WORDS(NUM_WORDS)) u_rb (
    .addr     (reg_addr),
    .en_all   (en_all),
    .pend_all (pend_vec),
    .rdata    (reg_rdata)
  );

  irq_out_stage #(.N(NUM_SRC)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_vec),
    .irq_q (irq_out)
  );

  // R7: no strobe hit, no change to any enable
  a_r7_other_writes_inert: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_write |=> $stable(en_all));

  // R1: the line is low whenever no source is enabled for a full cycle
  a_r1_no_enable_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all == '0) |=> !irq_out);
endmodule

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] req = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [63:0] en_m;
  logic        irq_m;

  always #4 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(req), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_out(irq)
  );

  // behavioural reference, one bit at a time
  always @(posedge clk) begin
    if (!rst_n) begin
      en_m  = '0;
      irq_m = 1'b0;
    end else begin
      irq_m = 1'b0;
      for (int b = 0; b < 64; b++) if (req[b] && en_m[b]) irq_m = 1'b1;
      if (wr) begin
        for (int b = 0; b < 64; b++) begin
          if (addr == 12'h210 + 12'((b / 32) * 4) && wdata[b % 32]) en_m[b] = 1'b1;
          if (addr == 12'h220 + 12'((b / 32) * 4) && wdata[b % 32]) en_m[b] = 1'b0;
        end
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      case (a)
        12'h200:          r[b] = req[b] & en_m[b];
        12'h204:          r[b] = req[b+32] & en_m[b+32];
        12'h210, 12'h220: r[b] = en_m[b];
        12'h214, 12'h224: r[b] = en_m[b+32];
        default:          r[b] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R6: line compared with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) chk("R6 irq_out per cycle", {31'd0, irq}, {31'd0, irq_m});
  end

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, string tag, logic [31:0] lit);
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
    chk({tag, " literal"}, rdata, lit);
  endtask

  task automatic rd_model(logic [11:0] a, string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: clean state after reset
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(12'h200, "R1 pend lo", 32'h0);
    rd(12'h204, "R1 pend hi", 32'h0);
    rd(12'h210, "R1 set lo", 32'h0);
    rd(12'h224, "R1 clr hi", 32'h0);

    // R4: requests without enables stay hidden
    req = 64'hFFFF_0000_0000_FFFF;
    @(negedge clk);
    rd(12'h200, "R4 masked lo", 32'h0);
    chk("R6 masked line low", {31'd0, irq}, 32'd0);

    // R2 and R5: timer lines 0-3 unmasked
    do_write(12'h210, 32'h0000_000F);
    rd(12'h210, "R5 set lo readback", 32'h0000_000F);
    rd(12'h220, "R5 clr lo readback", 32'h0000_000F);
    rd(12'h200, "R4 pend lo", 32'h0000_000F);
    @(negedge clk);
    chk("R6 line up", {31'd0, irq}, 32'd1);

    // R2: zero bits keep earlier enables
    do_write(12'h210, 32'h0001_0000);
    rd(12'h210, "R2 accumulate", 32'h0001_000F);

    // R2 high word: source 57 (bit 25 of high word)
    req = 64'h0;
    do_write(12'h214, 32'h0200_0000);
    rd(12'h214, "R2 set hi", 32'h0200_0000);
    req[57] = 1'b1;
    @(negedge clk);
    rd(12'h204, "R4 pend hi src57", 32'h0200_0000);
    rd(12'h200, "R4 pend lo idle", 32'h0);

    // R3: clear selected bits only
    do_write(12'h224, 32'h0200_0000);
    rd(12'h224, "R3 clr hi", 32'h0);
    do_write(12'h220, 32'h0000_0005);
    rd(12'h210, "R3 partial clear", 32'h0001_000A);

    // R2 and R3: all-zero writes are inert
    do_write(12'h210, 32'h0);
    do_write(12'h220, 32'h0);
    rd(12'h220, "R3 zero write", 32'h0001_000A);

    // R7: pending and unmapped writes are inert
    do_write(12'h200, 32'hFFFF_FFFF);
    do_write(12'h204, 32'hFFFF_FFFF);
    do_write(12'h218, 32'hFFFF_FFFF);
    do_write(12'h300, 32'hFFFF_FFFF);
    rd(12'h210, "R7 lo unchanged", 32'h0001_000A);
    rd(12'h214, "R7 hi unchanged", 32'h0);
    rd(12'h218, "R7 unmapped read", 32'h0);

    // R4 and R6: all enabled, several request patterns
    do_write(12'h210, 32'hFFFF_FFFF);
    do_write(12'h214, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      req = {32'hA5A5_0000 >> k, 32'h0000_3C3C << k};
      #1;
      rd_model(12'h200, "R4 pattern lo");
      rd_model(12'h204, "R4 pattern hi");
    end
    req = 64'h0;
    repeat (2) @(negedge clk);
    chk("R6 line low with no request", {31'd0, irq}, 32'd0);

    // R6: clearing all drops the line
    req = 64'h8000_0000_0000_0001;
    repeat (2) @(negedge clk);
    chk("R6 line high", {31'd0, irq}, 32'd1);
    do_write(12'h220, 32'hFFFF_FFFF);
    do_write(12'h224, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R6 line low after clear", {31'd0, irq}, 32'd0);
    rd(12'h204, "R3 all cleared", 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule